// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and date for a real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle `sec_tick` pulse, made elsewhere from the oscillator chain, moves the time on by one second. Carries ripple from seconds up to the year, with the correct month lengths and February 29 in leap years.

Each field is shown on its own output port in the encoding that two mode inputs select. `bin_mode` picks plain binary or packed BCD. `h24_mode` picks 24-hour or 12-hour hours. Software loads any field through a one-cycle write strobe. The write data is read in whatever encoding the mode inputs select at that moment. The block holds its state in binary and converts at its edges, so a mode change only changes how the same instant is shown.

Top module: `rtc_calendar`

## Requirements
- R1: When `rst_n` is low at a clock edge, the state becomes 00:00:00, day of week 1, day 1, month 1, year 00. In BCD 24-hour form the outputs then read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00.
- R2: The time changes only at a clock edge where `sec_tick` is high or a write happens. Each tick adds exactly one second.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R4: On a day carry, day of week goes from 7 back to 1 and otherwise goes up by one.
- R5: On a day carry, day of month goes back to 1 and month goes up by one once the month's length is reached. The lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 28 for month 2. Month 12 wraps to 1 and carries into the year, which wraps from 99 to 00.
- R6: February has 29 days when the two-digit year is divisible by 4, and year 00 counts as such a year.
- R7: With `bin_mode`=1 every output is plain binary. With `bin_mode`=0 it is packed BCD, with tens in bits 7:4 and units in bits 3:0.
- R8: With `h24_mode`=1 the hour reads 0 to 23. With `h24_mode`=0, bits 6:0 hold 12 for hour 0 and hour modulo 12 otherwise, and bit 7 is set for hours 12 to 23.
- R9: A write with `wr_en`=1 loads the field that `wr_sel` names. The codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month and 6 year. The data is decoded in the current modes, including the PM bit 7 in 12-hour form, and shows on the outputs after that edge.
- R10: A write at the same edge as a tick wins over the increment for the field it names. Every other field still advances, with carries taken from the values held before that edge.
- R11: A write with `wr_sel`=7 changes no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-second advance enable, one cycle wide |
| bin_mode | input | 1 | 1 = binary, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write value in the current encoding |
| sec_q | output | 8 | Seconds |
| min_q | output | 8 | Minutes |
| hour_q | output | 8 | Hours, with bit 7 as PM in 12-hour form |
| wday_q | output | 8 | Day of week, 1 to 7 |
| mday_q | output | 8 | Day of month |
| month_q | output | 8 | Month, 1 to 12 |
| year_q | output | 8 | Year modulo 100 |

## Verification
The counting function is tried with times that sit one second before each carry depth: a plain second step, a minute and hour carry, a day carry within a month, a carry at the end of 30-day and 31-day months, the end of February in a common year and in leap years including 00, and the end of the year. Running each of these in binary, BCD, 24-hour and 12-hour forms separates errors in the carry logic from errors in the encoding. The 11-to-12 and 23-to-0 hour steps show whether the PM flag and the 12 shown for hour 0 are placed correctly. Writes made at the same edge as a tick, one of them landing on a field that also receives a carry, check which source wins for each field.

// File: rtl/rtc_cal_pkg.sv
// Package: shared calendar types and pure conversion helpers.
// Assumes all values are held internally as 8-bit binary.
package rtc_cal_pkg;

    localparam int DW        = 8;
    localparam int NFIELD    = 7;
    localparam int SEL_W     = 3;
    localparam logic [DW-1:0] SEC_LAST  = 8'd59;
    localparam logic [DW-1:0] MIN_LAST  = 8'd59;
    localparam logic [DW-1:0] HOUR_LAST = 8'd23;
    localparam logic [DW-1:0] WDAY_LAST = 8'd7;
    localparam logic [DW-1:0] MON_LAST  = 8'd12;
    localparam logic [DW-1:0] YEAR_LAST = 8'd99;

    // field select codes used on the write port
    typedef enum logic [SEL_W-1:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_WDAY = 3'd3,
        F_MDAY = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6,
        F_NONE = 3'd7
    } field_e;

    typedef struct packed {
        logic [DW-1:0] sec;
        logic [DW-1:0] min;
        logic [DW-1:0] hour;
        logic [DW-1:0] wday;
        logic [DW-1:0] mday;
        logic [DW-1:0] mon;
        logic [DW-1:0] year;
    } cal_t;

    // binary value to output code (binary or packed BCD)
    function automatic logic [DW-1:0] to_code(input logic [DW-1:0] v, input logic bin);
        logic [DW-1:0] tens;
        logic [DW-1:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return bin ? v : {tens[3:0], ones[3:0]};
    endfunction

    // input code (binary or packed BCD) to binary value
    function automatic logic [DW-1:0] from_code(input logic [DW-1:0] c, input logic bin);
        return bin ? c : ({4'd0, c[7:4]} * 8'd10 + {4'd0, c[3:0]});
    endfunction

    // days in month; two-digit year divisible by 4 is a leap year
    function automatic logic [DW-1:0] month_len(input logic [DW-1:0] mon, input logic [DW-1:0] year);
        case (mon)
            8'd2:                    return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_next.sv
// Module: rtc_tick_next
// Computes the calendar one second after the given one, with the full
// carry chain. Purely combinational; assumes binary inputs.
module rtc_tick_next
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic c_min, c_hour, c_day, c_mon, c_year;

    // carry chain from seconds upward
    always_comb begin
        nxt    = cur;
        c_min  = (cur.sec  >= SEC_LAST);
        c_hour = c_min  && (cur.min  >= MIN_LAST);
        c_day  = c_hour && (cur.hour >= HOUR_LAST);
        c_mon  = c_day  && (cur.mday >= month_len(cur.mon, cur.year));
        c_year = c_mon  && (cur.mon  >= MON_LAST);

        nxt.sec = c_min ? '0 : cur.sec + 8'd1;
        if (c_min)  nxt.min  = c_hour ? '0 : cur.min + 8'd1;
        if (c_hour) nxt.hour = c_day ? '0 : cur.hour + 8'd1;
        if (c_day) begin
            nxt.wday = (cur.wday >= WDAY_LAST) ? 8'd1 : cur.wday + 8'd1;
            nxt.mday = c_mon ? 8'd1 : cur.mday + 8'd1;
        end
        if (c_mon)  nxt.mon  = c_year ? 8'd1 : cur.mon + 8'd1;
        if (c_year) nxt.year = (cur.year >= YEAR_LAST) ? '0 : cur.year + 8'd1;
    end
endmodule

// File: rtl/rtc_wr_decode.sv
// Module: rtc_wr_decode
// Turns a software write value into the binary field value, using the
// current encoding and hour-format modes. Combinational.
module rtc_wr_decode
    import rtc_cal_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [DW-1:0]    data,
    input  logic             bin_mode,
    input  logic             h24_mode,
    output logic [DW-1:0]    value
);
    logic [DW-1:0] raw;
    logic          pm;

    // decode, folding the 12-hour PM flag into a 0..23 hour
    always_comb begin
        pm  = 1'b0;
        raw = from_code(data, bin_mode);
        if ((sel == F_HOUR) && !h24_mode) begin
            pm  = data[7];
            raw = from_code({1'b0, data[6:0]}, bin_mode);
            if (raw == 8'd12) raw = pm ? 8'd12 : 8'd0;
            else if (pm)      raw = raw + 8'd12;
        end
        value = raw;
    end
endmodule

// File: rtl/rtc_field_enc.sv
// Module: rtc_field_enc
// Encodes one binary field for output. IS_HOUR selects the hour variant
// with 12-hour display and PM flag in bit 7.
module rtc_field_enc
    import rtc_cal_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [DW-1:0] value,
    input  logic          bin_mode,
    input  logic          h24_mode,
    output logic [DW-1:0] code
);
    generate
        if (IS_HOUR) begin : g_hour
            logic [DW-1:0] disp;
            logic [DW-1:0] enc;
            // 12-hour display: hour 0 and 12 both shown as 12
            always_comb begin
                disp = value % 8'd12;
                if (disp == '0) disp = 8'd12;
                enc  = to_code(h24_mode ? value : disp, bin_mode);
                code = h24_mode ? enc : {(value >= 8'd12), enc[6:0]};
            end
        end else begin : g_plain
            // plain field: encoding only
            always_comb code = to_code(value, bin_mode);
        end
    endgenerate
endmodule

// File: rtl/rtc_calendar.sv
// Module: rtc_calendar (top)
// Holds the time and date in binary, advances it on sec_tick, loads
// fields from software writes and shows them in the selected encoding.
// Assumes sec_tick is one cycle wide; reset is synchronous, active low.
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             bin_mode,
    input  logic             h24_mode,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    sec_q,
    output logic [DW-1:0]    min_q,
    output logic [DW-1:0]    hour_q,
    output logic [DW-1:0]    wday_q,
    output logic [DW-1:0]    mday_q,
    output logic [DW-1:0]    month_q,
    output logic [DW-1:0]    year_q
);
    localparam cal_t RST_CAL = '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd1,
                                 mday: 8'd1, mon: 8'd1, year: 8'd0};

    cal_t          cal_r;
    cal_t          cal_inc;
    cal_t          cal_d;
    logic [DW-1:0] wr_val;
    logic [DW-1:0] plain_bin  [NFIELD-1];
    logic [DW-1:0] plain_code [NFIELD-1];

    rtc_tick_next u_next (.cur(cal_r), .nxt(cal_inc));

    rtc_wr_decode u_dec (
        .sel(wr_sel), .data(wr_data), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .value(wr_val)
    );

    // next state: increment on tick, then per-field write override
    always_comb begin
        cal_d = sec_tick ? cal_inc : cal_r;
        if (wr_en) begin
            case (wr_sel)
                F_SEC:   cal_d.sec  = wr_val;
                F_MIN:   cal_d.min  = wr_val;
                F_HOUR:  cal_d.hour = wr_val;
                F_WDAY:  cal_d.wday = wr_val;
                F_MDAY:  cal_d.mday = wr_val;
                F_MON:   cal_d.mon  = wr_val;
                F_YEAR:  cal_d.year = wr_val;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cal_r <= RST_CAL;
        else        cal_r <= cal_d;
    end

    // gather the non-hour fields for the encoder array
    always_comb begin
        plain_bin[0] = cal_r.sec;
        plain_bin[1] = cal_r.min;
        plain_bin[2] = cal_r.wday;
        plain_bin[3] = cal_r.mday;
        plain_bin[4] = cal_r.mon;
        plain_bin[5] = cal_r.year;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NFIELD - 1; gi++) begin : g_enc
            rtc_field_enc #(.IS_HOUR(1'b0)) u_enc (
                .value(plain_bin[gi]), .bin_mode(bin_mode),
                .h24_mode(h24_mode), .code(plain_code[gi])
            );
        end
    endgenerate

    rtc_field_enc #(.IS_HOUR(1'b1)) u_hour_enc (
        .value(cal_r.hour), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .code(hour_q)
    );

    assign sec_q   = plain_code[0];
    assign min_q   = plain_code[1];
    assign wday_q  = plain_code[2];
    assign mday_q  = plain_code[3];
    assign month_q = plain_code[4];
    assign year_q  = plain_code[5];
endmodule

// File: rtl/rtc_calendar_chk.sv
// Module: rtc_calendar_chk
// Port-level properties of rtc_calendar, bound to every instance.
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       bin_mode,
    input logic       h24_mode,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic [7:0] wday_q
);
    logic same_mode;
    assign same_mode = bin_mode && h24_mode;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !wr_en) |=>
            (!$stable(bin_mode) || !$stable(h24_mode) ||
             ($stable(sec_q) && $stable(min_q) && $stable(hour_q)))); // R2

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && same_mode && sec_q < 8'd59) |=>
            (!$stable(bin_mode) || !$stable(h24_mode) || sec_q == $past(sec_q) + 8'd1)); // R2

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && same_mode && sec_q == 8'd59 && min_q < 8'd59) |=>
            (!$stable(bin_mode) || !$stable(h24_mode) ||
             (sec_q == 8'd0 && min_q == $past(min_q) + 8'd1))); // R3

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && same_mode && sec_q == 8'd59 && min_q == 8'd59 &&
         hour_q == 8'd23 && wday_q == 8'd7) |=>
            (!$stable(bin_mode) || !$stable(h24_mode) || wday_q == 8'd1)); // R4

    AST_HOUR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !h24_mode |-> (hour_q[6:0] != 7'd0)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0 && bin_mode) |=>
            (!$stable(bin_mode) || sec_q == $past(wr_data))); // R10
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bin_mode(bin_mode),
    .h24_mode(h24_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q)
);

// File: tb/rtc_calendar_tb.sv
// Bench for rtc_calendar: vector table walk, then directed cases.
module rtc_calendar_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;
    localparam int VW         = 114;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, month_q, year_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q),
        .mday_q(mday_q), .month_q(month_q), .year_q(year_q)
    );

    // {bin, h24, preload sec,min,hour,wday,mday,mon,year (binary 24h), expected outputs}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b1,1'b1, 8'd56,8'd34,8'd12,8'd3,8'd15,8'd6,8'd21,  8'h39,8'h22,8'h0C,8'h03,8'h0F,8'h06,8'h15}, // R2 R7 binary step
        {1'b0,1'b1, 8'd59,8'd59,8'd23,8'd7,8'd31,8'd12,8'd99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, // R3 R4 R5 year end
        {1'b0,1'b1, 8'd59,8'd59,8'd23,8'd2,8'd28,8'd2,8'd23,  8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23}, // R5 common Feb
        {1'b0,1'b1, 8'd59,8'd59,8'd23,8'd4,8'd28,8'd2,8'd24,  8'h00,8'h00,8'h00,8'h05,8'h29,8'h02,8'h24}, // R6 leap Feb 28
        {1'b0,1'b1, 8'd59,8'd59,8'd23,8'd1,8'd28,8'd2,8'd0,   8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h00}, // R6 year 00
        {1'b0,1'b1, 8'd59,8'd59,8'd23,8'd5,8'd29,8'd2,8'd24,  8'h00,8'h00,8'h00,8'h06,8'h01,8'h03,8'h24}, // R6 leap Feb 29
        {1'b0,1'b1, 8'd59,8'd59,8'd23,8'd6,8'd30,8'd4,8'd5,   8'h00,8'h00,8'h00,8'h07,8'h01,8'h05,8'h05}, // R5 30-day month
        {1'b0,1'b0, 8'd59,8'd59,8'd11,8'd1,8'd10,8'd7,8'd30,  8'h00,8'h00,8'h92,8'h01,8'h10,8'h07,8'h30}, // R8 noon
        {1'b0,1'b0, 8'd59,8'd59,8'd23,8'd3,8'd10,8'd7,8'd30,  8'h00,8'h00,8'h12,8'h04,8'h11,8'h07,8'h30}, // R8 midnight
        {1'b1,1'b0, 8'd59,8'd59,8'd12,8'd1,8'd1,8'd1,8'd0,    8'h00,8'h00,8'h81,8'h01,8'h01,8'h01,8'h00}, // R8 1 PM binary
        {1'b1,1'b0, 8'd59,8'd30,8'd9,8'd2,8'd5,8'd8,8'd50,    8'h00,8'h1F,8'h09,8'h02,8'h05,8'h08,8'h32}, // R3 R8 AM binary
        {1'b0,1'b1, 8'd59,8'd59,8'd23,8'd1,8'd31,8'd1,8'd10,  8'h00,8'h00,8'h00,8'h02,8'h01,8'h02,8'h10}  // R5 31-day month
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [55:0] exp);
        check(req, "sec",   sec_q,   exp[55:48]);
        check(req, "min",   min_q,   exp[47:40]);
        check(req, "hour",  hour_q,  exp[39:32]);
        check(req, "wday",  wday_q,  exp[31:24]);
        check(req, "mday",  mday_q,  exp[23:16]);
        check(req, "month", month_q, exp[15:8]);
        check(req, "year",  year_q,  exp[7:0]);
    endtask

    // one cycle with optional tick and write; ends on a negedge after the update
    task automatic cycle(input logic tk, input logic we, input logic [2:0] sel, input logic [7:0] d);
        sec_tick = tk; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic preload(input logic [55:0] p);
        bin_mode = 1'b1; h24_mode = 1'b1;
        for (int f = 0; f < 7; f++) cycle(1'b0, 1'b1, 3'(f), p[55 - 8*f -: 8]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1", {8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00});
        h24_mode = 1'b0; #1;
        check("R8", "reset hour 12h", hour_q, 8'h12);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            preload(VEC[i][111:56]);
            bin_mode = VEC[i][113]; h24_mode = VEC[i][112];
            cycle(1'b1, 1'b0, 3'd0, 8'd0);
            check_all($sformatf("vector %0d (R2-chain)", i), VEC[i][55:0]);
        end

        // R2 hold with no tick
        bin_mode = 1'b0; h24_mode = 1'b1;
        preload({8'd7,8'd8,8'd9,8'd3,8'd4,8'd5,8'd6});
        bin_mode = 1'b0; h24_mode = 1'b1;
        repeat (5) cycle(1'b0, 1'b0, 3'd0, 8'd0);
        check_all("R2 idle hold", {8'h07,8'h08,8'h09,8'h03,8'h04,8'h05,8'h06});

        // R9 hour write decode in 12-hour BCD
        bin_mode = 1'b0; h24_mode = 1'b0;
        cycle(1'b0, 1'b1, 3'd2, 8'h87);
        bin_mode = 1'b1; h24_mode = 1'b1; #1;
        check("R9", "7 PM write", hour_q, 8'd19);
        bin_mode = 1'b0; h24_mode = 1'b0;
        cycle(1'b0, 1'b1, 3'd2, 8'h12);
        bin_mode = 1'b1; h24_mode = 1'b1; #1;
        check("R9", "12 AM write", hour_q, 8'd0);
        bin_mode = 1'b0; h24_mode = 1'b0;
        cycle(1'b0, 1'b1, 3'd2, 8'h92);
        bin_mode = 1'b1; h24_mode = 1'b1; #1;
        check("R9", "12 PM write", hour_q, 8'd12);

        // R10 write at the same edge as a tick
        bin_mode = 1'b0; h24_mode = 1'b1;
        cycle(1'b0, 1'b1, 3'd0, 8'h10);
        cycle(1'b1, 1'b1, 3'd0, 8'h45);
        check("R10", "sec write wins", sec_q, 8'h45);
        cycle(1'b0, 1'b1, 3'd0, 8'h59);
        cycle(1'b0, 1'b1, 3'd1, 8'h05);
        cycle(1'b1, 1'b1, 3'd1, 8'h20);
        check("R10", "min write wins", min_q, 8'h20);
        check("R10", "sec still wraps", sec_q, 8'h00);

        // R11 select 7 ignored
        cycle(1'b0, 1'b1, 3'd7, 8'h33);
        check("R11", "sec after sel 7", sec_q, 8'h00);
        check("R11", "min after sel 7", min_q, 8'h20);
        check("R11", "year after sel 7", year_q, 8'h06);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule